// File: doc/BRIEF.md
# NAND page operation sequencer

This block takes a single request from the host side (read one page, program one page, or erase one block) and turns it into the byte-wide transaction sequence that a NAND flash die expects on its shared I/O bus. One byte moves per clock cycle. The level of the command-latch strobe or the address-latch strobe tells the die whether a byte is a command, an address or data. After the confirm command the block waits for the ready/busy line to fall and then rise again. For program and erase it then asks the die for its status byte and judges pass or fail from bit 0. A read instead streams the page out one byte per cycle.

The page to be programmed sits in a small internal buffer. The host fills that buffer before it issues the request. The buffer contents are never consumed, so a failed program can be re-run in full with identical data until a retry budget runs out. The wait on the busy line is bounded by a cycle limit that the host drives. The block answers each accepted request with a one-cycle response carrying OK, FAIL or TIMEOUT.

States: `S_IDLE` (ready for a request), `S_CMD1` (first opcode), `S_COL` (column bytes), `S_ROW` (row bytes), `S_DIN` (page bytes out), `S_CMD2` (confirm opcode), `S_WAIT_LO` (waiting for busy), `S_WAIT_HI` (waiting for ready), `S_STAT_CMD` (status opcode), `S_STAT_RD` (status byte in), `S_DOUT` (page bytes in), `S_RESP` (response pulse).

Transitions:
- `S_IDLE`→`S_CMD1` when a valid request arrives.
- `S_CMD1`→`S_COL`, or →`S_ROW` for an erase.
- `S_COL`→`S_ROW` after the last column byte.
- `S_ROW`→`S_DIN` for a program, otherwise →`S_CMD2`.
- `S_DIN`→`S_CMD2` after the last page byte.
- `S_CMD2`→`S_WAIT_LO`.
- `S_WAIT_LO`→`S_WAIT_HI` when the line goes busy, or →`S_RESP` when the limit expires.
- `S_WAIT_HI`→`S_DOUT` for a read or →`S_STAT_CMD` otherwise once the line is ready, or →`S_RESP` when the limit expires.
- `S_STAT_CMD`→`S_STAT_RD`.
- `S_STAT_RD`→`S_CMD1` for a program retry, otherwise →`S_RESP`.
- `S_DOUT`→`S_RESP` after the last byte.
- `S_RESP`→`S_IDLE`.

Top module: `nand_page_seq`

## Requirements
- R1: In every cycle at most one byte is on the bus. The command strobe and the address strobe are never high together. The write and read strobes are never low together. A latch strobe is high only while the write strobe is low.
- R2: A program sends these bytes in order: opcode 80h with the command strobe; the COL_BYTES column bytes, least significant first, with the address strobe; the ROW_BYTES row bytes, least significant first; PAGE_BYTES data bytes from buffer entries 0 upward with neither strobe; then the confirm opcode 10h.
- R3: After any confirm opcode the block waits until the ready/busy input is seen low and then high. A program or erase then sends opcode 70h and pulses the read strobe once to take a status byte, in which bit 0 = 1 means failure.
- R4: A failed program repeats the whole program sequence with the same buffer data, up to MAX_RETRY extra times. The first passing status gives an OK response (code 0).
- R5: When all 1+MAX_RETRY attempts of a program report failure, the response code is FAIL (1).
- R6: A read sends 00h, the column bytes, the row bytes and 30h, then waits. It then pulses the read strobe PAGE_BYTES times. Each sampled byte appears on rd_data with rd_valid high one cycle later. No status opcode is sent, and the response is OK.
- R7: An erase sends 60h, only the ROW_BYTES row bytes and D0h, with no column bytes, then reads status. A failing erase gives FAIL at once, with no retry.
- R8: If the ready/busy input has not reached the awaited level after busy_limit+1 cycles in either wait state, the response is TIMEOUT (2) on the next cycle and no status opcode is sent.
- R9: rsp_valid is high for exactly one cycle per accepted request. req_ready is high only in the idle state, and the bus is quiet while it is high.
- R10: A request with op code 3 is ignored: no bus activity and no response follow. Op codes are 0 = read, 1 = program, 2 = erase.
- R11: After reset all strobes are inactive (write and read strobes high, latch strobes low), req_ready is high, and rsp_valid and rd_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken while req_ready is high |
| req_op | input | 2 | 0 read, 1 program, 2 erase, 3 ignored |
| req_col | input | COL_BYTES*8 | Column address |
| req_row | input | ROW_BYTES*8 | Row (page/block) address |
| req_ready | output | 1 | Block is idle and takes a request |
| busy_limit | input | TMO_W | Cycle limit for each busy wait |
| wb_we | input | 1 | Page buffer write enable |
| wb_addr | input | $clog2(PAGE_BYTES) | Page buffer write index |
| wb_data | input | 8 | Page buffer write byte |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_code | output | 2 | 0 OK, 1 FAIL, 2 TIMEOUT |
| rd_valid | output | 1 | Read byte strobe |
| rd_data | output | 8 | Byte read from the page |
| nf_cle | output | 1 | Command latch strobe |
| nf_ale | output | 1 | Address latch strobe |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_out | output | 8 | Byte driven onto the I/O bus |
| nf_dq_oe | output | 1 | Drive enable for nf_dq_out |
| nf_dq_in | input | 8 | Byte returned by the die |
| nf_rb_n | input | 1 | Ready/busy, low while busy |

## Verification
The bound checker watches the strobe rules on every cycle: latch exclusivity, exclusive read and write strobes, latch strobes only with a write strobe, a quiet bus while idle, a one-cycle response with a legal code, and the return to idle after it. Only the bench can show what the byte stream contains. It checks the opcode order, the column and row byte order, that the same data is resent on every retry, and that the retry budget ends in FAIL. Its timeout scenarios also count the exact number of cycles the block waits in each wait state.

// File: rtl/nps_pkg.sv
package nps_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        RSP_OK      = 2'd0,
        RSP_FAIL    = 2'd1,
        RSP_TIMEOUT = 2'd2
    } rsp_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CMD1,
        S_COL,
        S_ROW,
        S_DIN,
        S_CMD2,
        S_WAIT_LO,
        S_WAIT_HI,
        S_STAT_CMD,
        S_STAT_RD,
        S_DOUT,
        S_RESP
    } state_e;

    localparam logic [7:0] OPC_STATUS = 8'h70;

    // opcode that opens a transaction
    function automatic logic [7:0] opc_open(op_e op);
        logic [7:0] r;
        unique case (op)
            OP_READ:  r = 8'h00;
            OP_PROG:  r = 8'h80;
            OP_ERASE: r = 8'h60;
            default:  r = 8'h00;
        endcase
        return r;
    endfunction

    // opcode that starts the array operation
    function automatic logic [7:0] opc_confirm(op_e op);
        logic [7:0] r;
        unique case (op)
            OP_READ:  r = 8'h30;
            OP_PROG:  r = 8'h10;
            OP_ERASE: r = 8'hD0;
            default:  r = 8'h30;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/nps_page_buf.sv
module nps_page_buf #(
    parameter int DEPTH = 8,
    parameter int AW    = 3
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // read is never destructive: a retry replays the same bytes
    assign rdata = mem[raddr];

endmodule

// File: rtl/nps_addr_mux.sv
module nps_addr_mux #(
    parameter int COL_BYTES = 2,
    parameter int ROW_BYTES = 3,
    parameter int IW        = 4
) (
    input  logic [COL_BYTES*8-1:0] col,
    input  logic [ROW_BYTES*8-1:0] row,
    input  logic                   use_row,
    input  logic [IW-1:0]          idx,
    output logic [7:0]             byte_o
);

    logic [7:0] col_b [COL_BYTES];
    logic [7:0] row_b [ROW_BYTES];

    for (genvar g = 0; g < COL_BYTES; g++) begin : g_col
        assign col_b[g] = col[g*8 +: 8];
    end
    for (genvar g = 0; g < ROW_BYTES; g++) begin : g_row
        assign row_b[g] = row[g*8 +: 8];
    end

    // least significant byte leaves first
    always_comb begin
        byte_o = 8'h00;
        for (int i = 0; i < COL_BYTES; i++) begin
            if (!use_row && idx == IW'(i)) byte_o = col_b[i];
        end
        for (int i = 0; i < ROW_BYTES; i++) begin
            if (use_row && idx == IW'(i)) byte_o = row_b[i];
        end
    end

endmodule

// File: rtl/nps_busy_timer.sv
module nps_busy_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (run && cnt_q != '1) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && (cnt_q >= limit);

endmodule

// File: rtl/nand_page_seq.sv
module nand_page_seq
    import nps_pkg::*;
#(
    parameter int PAGE_BYTES = 8,
    parameter int COL_BYTES  = 2,
    parameter int ROW_BYTES  = 3,
    parameter int MAX_RETRY  = 3,
    parameter int TMO_W      = 16,
    localparam int PB_W      = $clog2(PAGE_BYTES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [1:0]             req_op,
    input  logic [COL_BYTES*8-1:0] req_col,
    input  logic [ROW_BYTES*8-1:0] req_row,
    output logic                   req_ready,
    input  logic [TMO_W-1:0]       busy_limit,
    input  logic                   wb_we,
    input  logic [PB_W-1:0]        wb_addr,
    input  logic [7:0]             wb_data,
    output logic                   rsp_valid,
    output logic [1:0]             rsp_code,
    output logic                   rd_valid,
    output logic [7:0]             rd_data,
    output logic                   nf_cle,
    output logic                   nf_ale,
    output logic                   nf_we_n,
    output logic                   nf_re_n,
    output logic [7:0]             nf_dq_out,
    output logic                   nf_dq_oe,
    input  logic [7:0]             nf_dq_in,
    input  logic                   nf_rb_n
);

    localparam int MAX_CR = (COL_BYTES > ROW_BYTES) ? COL_BYTES : ROW_BYTES;
    localparam int MAXN   = (PAGE_BYTES > MAX_CR) ? PAGE_BYTES : MAX_CR;
    localparam int IW     = $clog2(MAXN + 1);
    localparam int TW     = $clog2(MAX_RETRY + 1);

    localparam logic [IW-1:0] COL_LAST  = IW'(COL_BYTES - 1);
    localparam logic [IW-1:0] ROW_LAST  = IW'(ROW_BYTES - 1);
    localparam logic [IW-1:0] PAGE_LAST = IW'(PAGE_BYTES - 1);
    localparam logic [TW-1:0] RETRY_TOP = TW'(MAX_RETRY);

    state_e                 state_q, state_d;
    op_e                    op_q;
    logic [COL_BYTES*8-1:0] col_q;
    logic [ROW_BYTES*8-1:0] row_q;
    logic [IW-1:0]          idx_q;
    logic [TW-1:0]          tries_q;
    rsp_e                   rsp_q;
    logic                   rd_valid_q;
    logic [7:0]             rd_data_q;

    logic       req_take;
    logic       counting;
    logic       stat_fail;
    logic       can_retry;
    logic [7:0] addr_byte;
    logic [7:0] buf_byte;
    logic       tmr_clr, tmr_run, tmr_exp;

    assign req_take  = req_valid && (req_op != 2'd3);
    assign counting  = (state_q == S_COL) || (state_q == S_ROW) ||
                       (state_q == S_DIN) || (state_q == S_DOUT);
    assign stat_fail = nf_dq_in[0];
    assign can_retry = (op_q == OP_PROG) && (tries_q != RETRY_TOP);

    // each wait state starts with a fresh count
    assign tmr_run = (state_q == S_WAIT_LO) || (state_q == S_WAIT_HI);
    assign tmr_clr = (state_q == S_CMD2) || ((state_q == S_WAIT_LO) && !nf_rb_n);

    nps_addr_mux #(
        .COL_BYTES (COL_BYTES),
        .ROW_BYTES (ROW_BYTES),
        .IW        (IW)
    ) u_addr (
        .col     (col_q),
        .row     (row_q),
        .use_row (state_q == S_ROW),
        .idx     (idx_q),
        .byte_o  (addr_byte)
    );

    nps_page_buf #(
        .DEPTH (PAGE_BYTES),
        .AW    (PB_W)
    ) u_buf (
        .clk   (clk),
        .we    (wb_we),
        .waddr (wb_addr),
        .wdata (wb_data),
        .raddr (idx_q[PB_W-1:0]),
        .rdata (buf_byte)
    );

    nps_busy_timer #(
        .W (TMO_W)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .run     (tmr_run),
        .limit   (busy_limit),
        .expired (tmr_exp)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (req_take) state_d = S_CMD1;
            S_CMD1:     state_d = (op_q == OP_ERASE) ? S_ROW : S_COL;
            S_COL:      if (idx_q == COL_LAST) state_d = S_ROW;
            S_ROW:      if (idx_q == ROW_LAST)
                            state_d = (op_q == OP_PROG) ? S_DIN : S_CMD2;
            S_DIN:      if (idx_q == PAGE_LAST) state_d = S_CMD2;
            S_CMD2:     state_d = S_WAIT_LO;
            S_WAIT_LO:  if (!nf_rb_n)     state_d = S_WAIT_HI;
                        else if (tmr_exp) state_d = S_RESP;
            S_WAIT_HI:  if (nf_rb_n)      state_d = (op_q == OP_READ) ? S_DOUT : S_STAT_CMD;
                        else if (tmr_exp) state_d = S_RESP;
            S_STAT_CMD: state_d = S_STAT_RD;
            S_STAT_RD:  state_d = (stat_fail && can_retry) ? S_CMD1 : S_RESP;
            S_DOUT:     if (idx_q == PAGE_LAST) state_d = S_RESP;
            S_RESP:     state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // request capture, byte index, retry count, response and read capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q       <= OP_READ;
            col_q      <= '0;
            row_q      <= '0;
            idx_q      <= '0;
            tries_q    <= '0;
            rsp_q      <= RSP_OK;
            rd_valid_q <= 1'b0;
            rd_data_q  <= 8'h00;
        end else begin
            if (state_d != state_q) begin
                idx_q <= '0;
            end else if (counting) begin
                idx_q <= idx_q + 1'b1;
            end

            if (state_q == S_IDLE && req_take) begin
                op_q    <= op_e'(req_op);
                col_q   <= req_col;
                row_q   <= req_row;
                tries_q <= '0;
            end

            if (state_q == S_STAT_RD) begin
                if (stat_fail && can_retry) begin
                    tries_q <= tries_q + 1'b1;
                end
                rsp_q <= stat_fail ? RSP_FAIL : RSP_OK;
            end else if (tmr_run && state_d == S_RESP) begin
                rsp_q <= RSP_TIMEOUT;
            end else if (state_q == S_DOUT) begin
                rsp_q <= RSP_OK;
            end

            rd_valid_q <= (state_q == S_DOUT);
            if (state_q == S_DOUT) begin
                rd_data_q <= nf_dq_in;
            end
        end
    end

    // bus and host outputs
    always_comb begin
        nf_cle    = 1'b0;
        nf_ale    = 1'b0;
        nf_we_n   = 1'b1;
        nf_re_n   = 1'b1;
        nf_dq_out = 8'h00;
        nf_dq_oe  = 1'b0;
        unique case (state_q)
            S_CMD1: begin
                nf_cle    = 1'b1;
                nf_we_n   = 1'b0;
                nf_dq_oe  = 1'b1;
                nf_dq_out = opc_open(op_q);
            end
            S_COL, S_ROW: begin
                nf_ale    = 1'b1;
                nf_we_n   = 1'b0;
                nf_dq_oe  = 1'b1;
                nf_dq_out = addr_byte;
            end
            S_DIN: begin
                nf_we_n   = 1'b0;
                nf_dq_oe  = 1'b1;
                nf_dq_out = buf_byte;
            end
            S_CMD2: begin
                nf_cle    = 1'b1;
                nf_we_n   = 1'b0;
                nf_dq_oe  = 1'b1;
                nf_dq_out = opc_confirm(op_q);
            end
            S_STAT_CMD: begin
                nf_cle    = 1'b1;
                nf_we_n   = 1'b0;
                nf_dq_oe  = 1'b1;
                nf_dq_out = OPC_STATUS;
            end
            S_STAT_RD, S_DOUT: begin
                nf_re_n   = 1'b0;
            end
            S_IDLE, S_WAIT_LO, S_WAIT_HI, S_RESP: begin
            end
            default: begin
            end
        endcase
    end

    assign req_ready = (state_q == S_IDLE);
    assign rsp_valid = (state_q == S_RESP);
    assign rsp_code  = rsp_q;
    assign rd_valid  = rd_valid_q;
    assign rd_data   = rd_data_q;

endmodule

// File: rtl/nps_seq_chk.sv
module nps_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       nf_cle,
    input logic       nf_ale,
    input logic       nf_we_n,
    input logic       nf_re_n,
    input logic       req_ready,
    input logic       rsp_valid,
    input logic [1:0] rsp_code
);

    AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(nf_cle && nf_ale)); // R1

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nf_we_n && !nf_re_n)); // R1

    AST_LATCH_NEEDS_WE: assert property (@(posedge clk) disable iff (!rst_n)
        (nf_cle || nf_ale) |-> !nf_we_n); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (nf_we_n && nf_re_n)); // R9

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R9

    AST_RSP_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_code != 2'd3)); // R9

    AST_IDLE_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> req_ready); // R9

    AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready); // R9

endmodule

bind nand_page_seq nps_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .nf_cle    (nf_cle),
    .nf_ale    (nf_ale),
    .nf_we_n   (nf_we_n),
    .nf_re_n   (nf_re_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_code  (rsp_code)
);

// File: tb/nand_page_seq_tb.sv
module nand_page_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int PAGE_BYTES = 8;
    localparam int COL_BYTES  = 2;
    localparam int ROW_BYTES  = 3;
    localparam int MAX_RETRY  = 3;
    localparam int TMO_W      = 16;
    localparam int PRE        = 2;
    localparam int LEN        = 3;
    localparam int WD_CYCLES  = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [15:0] req_col = '0;
    logic [23:0] req_row = '0;
    logic        req_ready;
    logic [15:0] busy_limit = 16'd20;
    logic        wb_we = 1'b0;
    logic [2:0]  wb_addr = '0;
    logic [7:0]  wb_data = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_code;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic        nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
    logic [7:0]  nf_dq_out;
    logic [7:0]  nf_dq_in = 8'h00;
    logic        nf_rb_n = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_page_seq #(
        .PAGE_BYTES (PAGE_BYTES),
        .COL_BYTES  (COL_BYTES),
        .ROW_BYTES  (ROW_BYTES),
        .MAX_RETRY  (MAX_RETRY),
        .TMO_W      (TMO_W)
    ) u_dut (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_op (req_op), .req_col (req_col), .req_row (req_row),
        .req_ready (req_ready), .busy_limit (busy_limit),
        .wb_we (wb_we), .wb_addr (wb_addr), .wb_data (wb_data),
        .rsp_valid (rsp_valid), .rsp_code (rsp_code), .rd_valid (rd_valid), .rd_data (rd_data),
        .nf_cle (nf_cle), .nf_ale (nf_ale), .nf_we_n (nf_we_n), .nf_re_n (nf_re_n),
        .nf_dq_out (nf_dq_out), .nf_dq_oe (nf_dq_oe), .nf_dq_in (nf_dq_in), .nf_rb_n (nf_rb_n)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // ---------------- flash die model and bus monitor ----------------
    logic [9:0] log_q [128];
    int         log_n = 0;
    logic [7:0] rdl [16];
    int         rdl_n = 0;
    logic [7:0] pages [4][8];
    logic [7:0] tmp [8];
    logic [7:0] al [8];
    int         al_n = 0, din_n = 0, rd_ptr = 0;
    int         since = -1;
    int         cyc = 0, cfm_cyc = 0, rsp_cyc = 0, rsp_cnt = 0;
    int         viol = 0;
    int         fail_left = 0;
    bit         erase_fail = 0, hang_lo = 0, hang_hi = 0, stat_mode = 0;
    logic [7:0] first_op = 8'h00;
    logic [7:0] status = 8'h00;
    logic [1:0] cur_row = 2'd0;
    logic [1:0] rsp_seen = 2'd0;

    always @(negedge clk) begin
        cyc++;
        if (since >= 0) since++;
        if ((nf_cle && nf_ale) || (!nf_we_n && !nf_re_n) || ((nf_cle || nf_ale) && nf_we_n))
            viol++;
        if (!nf_we_n) begin
            if (log_n < 128) log_q[log_n] = {nf_cle, nf_ale, nf_dq_out};
            log_n++;
            if (nf_cle) begin
                case (nf_dq_out)
                    8'h80, 8'h00, 8'h60: begin
                        first_op = nf_dq_out; al_n = 0; din_n = 0; stat_mode = 0;
                    end
                    8'h10, 8'h30, 8'hD0: begin
                        since = 0; cfm_cyc = cyc; rd_ptr = 0;
                        if (al_n >= 3) cur_row = al[al_n-3][1:0];
                    end
                    8'h70: begin
                        stat_mode = 1;
                        if (first_op == 8'h80) begin
                            if (fail_left > 0) begin
                                status = 8'h01; fail_left--;
                            end else begin
                                status = 8'h00;
                                for (int i = 0; i < 8; i++) pages[cur_row][i] = tmp[i];
                            end
                        end else begin
                            status = erase_fail ? 8'h01 : 8'h00;
                        end
                    end
                    default: ;
                endcase
            end else if (nf_ale) begin
                if (al_n < 8) al[al_n] = nf_dq_out;
                al_n++;
            end else begin
                if (din_n < 8) tmp[din_n] = nf_dq_out;
                din_n++;
            end
        end
        if (!nf_re_n) begin
            nf_dq_in = stat_mode ? status : pages[cur_row][rd_ptr % 8];
            rd_ptr++;
        end
        if (rd_valid) begin
            if (rdl_n < 16) rdl[rdl_n] = rd_data;
            rdl_n++;
        end
        if (rsp_valid) begin
            rsp_cnt++; rsp_seen = rsp_code; rsp_cyc = cyc;
        end
        if (hang_lo) nf_rb_n = 1'b1;
        else if (since >= PRE && (hang_hi || since < PRE + LEN)) nf_rb_n = 1'b0;
        else nf_rb_n = 1'b1;
        if (cyc == WD_CYCLES) begin
            check(0, "watchdog", cyc, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // ---------------- expected stream helpers ----------------
    logic [9:0] exp_q [128];
    int         exp_n = 0;

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 37 + i * 11) ^ 8'h5A);
    endfunction

    task automatic push(input logic [1:0] kind, input logic [7:0] b);
        if (exp_n < 128) exp_q[exp_n] = {kind, b};
        exp_n++;
    endtask

    task automatic exp_prog(input logic [15:0] col, input logic [23:0] row, input int seed);
        push(2'b10, 8'h80);
        for (int i = 0; i < COL_BYTES; i++) push(2'b01, col[i*8 +: 8]);
        for (int i = 0; i < ROW_BYTES; i++) push(2'b01, row[i*8 +: 8]);
        for (int i = 0; i < PAGE_BYTES; i++) push(2'b00, pat(seed, i));
        push(2'b10, 8'h10);
        push(2'b10, 8'h70);
    endtask

    task automatic exp_read(input logic [15:0] col, input logic [23:0] row);
        push(2'b10, 8'h00);
        for (int i = 0; i < COL_BYTES; i++) push(2'b01, col[i*8 +: 8]);
        for (int i = 0; i < ROW_BYTES; i++) push(2'b01, row[i*8 +: 8]);
        push(2'b10, 8'h30);
    endtask

    task automatic exp_erase(input logic [23:0] row, input bit with_status);
        push(2'b10, 8'h60);
        for (int i = 0; i < ROW_BYTES; i++) push(2'b01, row[i*8 +: 8]);
        push(2'b10, 8'hD0);
        if (with_status) push(2'b10, 8'h70);
    endtask

    task automatic cmp_log(input string req);
        int mism = 0;
        int fa = 0, fe = 0;
        check(log_n == exp_n, req, log_n, exp_n);
        for (int i = 0; i < exp_n && i < log_n && i < 128; i++) begin
            if (log_q[i] !== exp_q[i]) begin
                if (mism == 0) begin fa = int'(log_q[i]); fe = int'(exp_q[i]); end
                mism++;
            end
        end
        check(mism == 0, req, fa, fe);
    endtask

    task automatic sync();
        @(negedge clk);
        #1;
    endtask

    task automatic fill_buf(input int seed);
        for (int i = 0; i < PAGE_BYTES; i++) begin
            wb_we = 1'b1; wb_addr = 3'(i); wb_data = pat(seed, i);
            sync();
        end
        wb_we = 1'b0;
    endtask

    task automatic run_op(input logic [1:0] op, input logic [15:0] col, input logic [23:0] row);
        int guard = 0;
        log_n = 0; rdl_n = 0; rsp_cnt = 0; exp_n = 0;
        req_valid = 1'b1; req_op = op; req_col = col; req_row = row;
        sync();
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R9 ready low while busy", req_ready, 0);
        while (rsp_cnt == 0 && guard < 2000) begin
            sync();
            guard++;
        end
        sync();
        sync();
        check(rsp_cnt == 1, "R9 one response pulse", rsp_cnt, 1);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        logic [15:0] col;
        logic [23:0] row;
        int n80;
        for (int p = 0; p < 4; p++)
            for (int i = 0; i < 8; i++) pages[p][i] = 8'hFF;

        sync();
        check(nf_we_n == 1'b1 && nf_re_n == 1'b1, "R11 strobes idle in reset", {nf_we_n, nf_re_n}, 3);
        sync();
        rst_n = 1'b1;
        sync();
        check(nf_cle == 1'b0 && nf_ale == 1'b0, "R11 latch strobes low", {nf_cle, nf_ale}, 0);
        check(nf_we_n == 1'b1 && nf_re_n == 1'b1, "R11 write/read strobes high", {nf_we_n, nf_re_n}, 3);
        check(req_ready == 1'b1, "R11 ready after reset", req_ready, 1);
        check(rsp_valid == 1'b0 && rd_valid == 1'b0, "R11 no response", {rsp_valid, rd_valid}, 0);

        // R2 R3 R6: program then read back every modelled page
        for (int r = 0; r < 4; r++) begin
            col = 16'((r * 16'h0123) + 16'h00A5);
            row = 24'((r * 24'h010101) + 24'h040000) | 24'(r);
            fill_buf(r + 1);
            run_op(2'd1, col, row);
            exp_prog(col, row, r + 1);
            cmp_log("R2 program byte stream");
            check(rsp_seen == 2'd0, "R3 program pass status", rsp_seen, 0);

            run_op(2'd0, col, row);
            exp_read(col, row);
            cmp_log("R6 read byte stream");
            check(rsp_seen == 2'd0, "R6 read response", rsp_seen, 0);
            check(rdl_n == PAGE_BYTES, "R6 read byte count", rdl_n, PAGE_BYTES);
            for (int i = 0; i < PAGE_BYTES; i++)
                check(rdl[i] == pat(r + 1, i), "R6 read data", rdl[i], pat(r + 1, i));
        end

        // R4: two failures then pass, same data each time
        fill_buf(9);
        fail_left = 2;
        run_op(2'd1, 16'h0010, 24'h000005);
        for (int a = 0; a < 3; a++) exp_prog(16'h0010, 24'h000005, 9);
        cmp_log("R4 retried program stream");
        check(rsp_seen == 2'd0, "R4 retry ends OK", rsp_seen, 0);
        fill_buf(13);
        run_op(2'd0, 16'h0010, 24'h000005);
        for (int i = 0; i < PAGE_BYTES; i++)
            check(rdl[i] == pat(9, i), "R4 retried data stored", rdl[i], pat(9, i));

        // R5: retries exhausted
        fail_left = 10;
        run_op(2'd1, 16'h0000, 24'h000002);
        n80 = 0;
        for (int i = 0; i < log_n && i < 128; i++) if (log_q[i] == {2'b10, 8'h80}) n80++;
        check(n80 == 1 + MAX_RETRY, "R5 attempt count", n80, 1 + MAX_RETRY);
        for (int a = 0; a <= MAX_RETRY; a++) exp_prog(16'h0000, 24'h000002, 13);
        cmp_log("R5 exhausted stream");
        check(rsp_seen == 2'd1, "R5 FAIL response", rsp_seen, 1);
        fail_left = 0;

        // R7: erase pass and fail
        run_op(2'd2, 16'hBEEF, 24'hA1B2C3);
        exp_erase(24'hA1B2C3, 1);
        cmp_log("R7 erase stream");
        check(rsp_seen == 2'd0, "R7 erase OK", rsp_seen, 0);
        erase_fail = 1;
        run_op(2'd2, 16'h0000, 24'h123456);
        exp_erase(24'h123456, 1);
        cmp_log("R7 failing erase not retried");
        check(rsp_seen == 2'd1, "R7 erase FAIL", rsp_seen, 1);
        erase_fail = 0;

        // R8: busy never seen, then busy never released
        busy_limit = 16'd10;
        hang_lo = 1;
        run_op(2'd2, 16'h0000, 24'h000777);
        check(rsp_seen == 2'd2, "R8 timeout waiting for busy", rsp_seen, 2);
        check(rsp_cyc - cfm_cyc == 12, "R8 wait-low cycle count", rsp_cyc - cfm_cyc, 12);
        exp_erase(24'h000777, 0);
        cmp_log("R8 no status after timeout");
        hang_lo = 0;
        hang_hi = 1;
        run_op(2'd0, 16'h0001, 24'h000003);
        check(rsp_seen == 2'd2, "R8 timeout waiting for ready", rsp_seen, 2);
        check(rsp_cyc - cfm_cyc == 14, "R8 wait-high cycle count", rsp_cyc - cfm_cyc, 14);
        check(rdl_n == 0, "R8 no data after timeout", rdl_n, 0);
        hang_hi = 0;
        busy_limit = 16'd20;
        repeat (4) sync();

        // R10: op code 3 ignored
        log_n = 0; rsp_cnt = 0;
        req_valid = 1'b1; req_op = 2'd3;
        repeat (6) sync();
        check(req_ready == 1'b1, "R10 stays idle", req_ready, 1);
        req_valid = 1'b0;
        repeat (3) sync();
        check(log_n == 0, "R10 no bus bytes", log_n, 0);
        check(rsp_cnt == 0, "R10 no response", rsp_cnt, 0);

        // R1: strobe rules over the whole run
        check(viol == 0, "R1 strobe exclusivity", viol, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule